// File: doc/BRIEF.md
# USB OUT Endpoint Receive Bank

This block is the receive buffer for one USB device OUT endpoint. An upstream serial engine delivers each packet already decoded: a start strobe, then one data-valid strobe per byte, then an end strobe that carries a CRC-status bit. The block stores the bytes in one bank whose size is a parameter. It keeps a count of stored bytes and lets the CPU drain the bank one byte per read strobe.

When a packet completes, the block raises a received-data flag. Three error conditions get their own sticky flags. A packet that arrives while the bank still holds unread data is dropped and raises underflow. A packet longer than the bank is cut to the bank size and raises overflow, but it still counts as a normally received packet. A corrupted packet on an isochronous endpoint is stored and raises a CRC error; on other endpoint types the CRC status is ignored. The received-data flag and each error flag are gated by their own enable bits and ORed into one registered endpoint interrupt.

The end strobe arrives in a cycle after the last data strobe. A data strobe in the same cycle as the end strobe is ignored.

Top module: `usb_out_bank`

## Requirements
- R1: After reset, `rx_flag`, `ovf_flag`, `udf_flag`, `crc_flag`, `ep_irq` and `cpu_rd_ok` are 0 and `byte_cnt` is 0.
- R2: A packet that starts while `rx_flag` is 0 is stored from bank address 0 upward. On the clock edge of its end strobe, `rx_flag` goes to 1 and `byte_cnt` equals the packet length.
- R3: A packet longer than `BANK_BYTES` keeps only its first `BANK_BYTES` bytes. `byte_cnt` saturates at `BANK_BYTES`, `ovf_flag` is set, and `rx_flag` is set as for a normal packet. A packet of exactly `BANK_BYTES` does not set `ovf_flag`.
- R4: A start strobe while `rx_flag` is 1 sets `udf_flag`, and the whole packet is discarded: bank contents and `byte_cnt` are unchanged.
- R5: With `cfg_iso`=1, a packet whose end strobe has `pkt_crc_bad`=1 is stored, and it sets both `crc_flag` and `rx_flag`. With `cfg_iso`=0, `pkt_crc_bad` has no effect on `crc_flag`.
- R6: `cpu_rd_ok` is 1 only while `rx_flag` is 1 and unread bytes remain. `cpu_rd_data` shows the byte at the read pointer. A `cpu_rd` strobe advances the pointer only when `cpu_rd_ok` is 1; otherwise it is ignored.
- R7: `clr_rx` clears `rx_flag`, sets `byte_cnt` to 0 and returns the read pointer to address 0.
- R8: `ovf_flag`, `udf_flag` and `crc_flag` stay set until their own clear strobe (`clr_ovf`, `clr_udf`, `clr_crc`). If a set and a clear happen in the same cycle, the flag ends up set.
- R9: `ep_irq` is a register. Each cycle it loads the OR of (`rx_flag`&`en_rx`), (`ovf_flag`&`en_ovf`), (`udf_flag`&`en_udf`) and (`crc_flag`&`en_crc`), so it follows a flag or an enable change one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_start | input | 1 | Packet start strobe |
| pkt_byte_vld | input | 1 | Data byte valid strobe |
| pkt_byte | input | DATA_W | Received data byte |
| pkt_end | input | 1 | Packet end strobe |
| pkt_crc_bad | input | 1 | CRC failure status, sampled with `pkt_end` |
| cfg_iso | input | 1 | Endpoint is isochronous OUT |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_rd_data | output | DATA_W | Byte at the read pointer |
| cpu_rd_ok | output | 1 | Read allowed: data present and unread |
| clr_rx | input | 1 | Clear received flag and empty the bank |
| clr_ovf | input | 1 | Clear overflow flag |
| clr_udf | input | 1 | Clear underflow flag |
| clr_crc | input | 1 | Clear CRC error flag |
| en_rx | input | 1 | Interrupt enable, received data |
| en_ovf | input | 1 | Interrupt enable, overflow |
| en_udf | input | 1 | Interrupt enable, underflow |
| en_crc | input | 1 | Interrupt enable, CRC error |
| rx_flag | output | 1 | Received-data flag |
| ovf_flag | output | 1 | Overflow flag |
| udf_flag | output | 1 | Underflow flag |
| crc_flag | output | 1 | CRC error flag |
| byte_cnt | output | CNT_W | Bytes stored in the bank |
| ep_irq | output | 1 | Registered endpoint interrupt |

## Verification
The bench targets packet lengths on both sides of the bank size. A design with an off-by-one room test would flag an exact-fit packet as overflow, or would write one byte past the end. It sends a second packet into a full bank and reads back the first packet's leading byte, which exposes a design that overwrites the bank instead of dropping the packet. It applies a bad CRC on both isochronous and bulk endpoints, strobes reads into an empty bank, and then checks that later data still starts at byte 0; a design that let those reads move the pointer would return a later byte. It also pulses a flag clear in the same cycle as a new set, and checks the one-cycle interrupt lag after an enable or a flag changes.

// File: rtl/usb_out_bank_pkg.sv
package usb_out_bank_pkg;
  // flag vector order: {crc, udf, ovf, rx}
  typedef struct packed {
    logic crc;
    logic udf;
    logic ovf;
    logic rx;
  } ep_flags_t;

  function automatic logic irq_reduce(ep_flags_t f, ep_flags_t en);
    return |(f & en);
  endfunction

  function automatic logic sticky_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/usb_out_bank_mem.sv
module usb_out_bank_mem #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/usb_out_bank_rx.sv
module usb_out_bank_rx #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pkt_start,
  input  logic          pkt_byte_vld,
  input  logic          pkt_end,
  input  logic          pkt_crc_bad,
  input  logic          cfg_iso,
  input  logic          rx_flag,
  input  logic          clr_rx,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [CW-1:0] cnt,
  output logic          start_ok,
  output logic          done_evt,
  output logic          ovf_evt,
  output logic          udf_evt,
  output logic          crc_evt
);
  logic in_pkt;
  logic trunc;
  logic room;
  logic byte_take;

  assign room      = cnt < CW'(DEPTH);
  assign start_ok  = pkt_start & ~rx_flag;
  assign udf_evt   = pkt_start & rx_flag;
  assign byte_take = in_pkt & pkt_byte_vld & ~pkt_end;
  assign wr_en     = byte_take & room;
  assign wr_addr   = cnt[AW-1:0];
  assign done_evt  = in_pkt & pkt_end;
  assign ovf_evt   = done_evt & trunc;
  assign crc_evt   = done_evt & pkt_crc_bad & cfg_iso;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt <= 1'b0;
      trunc  <= 1'b0;
      cnt    <= '0;
    end else if (start_ok) begin
      in_pkt <= 1'b1;
      trunc  <= 1'b0;
      cnt    <= '0;
    end else begin
      if (pkt_end) in_pkt <= 1'b0;
      if (byte_take && !room) trunc <= 1'b1;
      if (wr_en) cnt <= cnt + 1'b1;
      else if (clr_rx && !in_pkt) cnt <= '0;
    end
  end
endmodule

// File: rtl/usb_out_bank_flags.sv
module usb_out_bank_flags
  import usb_out_bank_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  ep_flags_t set_v,
  input  ep_flags_t clr_v,
  input  ep_flags_t en_v,
  output ep_flags_t flags,
  output logic      irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags.rx  <= sticky_next(flags.rx,  set_v.rx,  clr_v.rx);
      flags.ovf <= sticky_next(flags.ovf, set_v.ovf, clr_v.ovf);
      flags.udf <= sticky_next(flags.udf, set_v.udf, clr_v.udf);
      flags.crc <= sticky_next(flags.crc, set_v.crc, clr_v.crc);
      irq       <= irq_reduce(flags, en_v);
    end
  end
endmodule

// File: rtl/usb_out_bank.sv
module usb_out_bank
  import usb_out_bank_pkg::*;
#(
  parameter int BANK_BYTES = 64,
  parameter int DATA_W     = 8,
  localparam int AW        = $clog2(BANK_BYTES),
  localparam int CNT_W     = $clog2(BANK_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_start,
  input  logic              pkt_byte_vld,
  input  logic [DATA_W-1:0] pkt_byte,
  input  logic              pkt_end,
  input  logic              pkt_crc_bad,
  input  logic              cfg_iso,
  input  logic              cpu_rd,
  output logic [DATA_W-1:0] cpu_rd_data,
  output logic              cpu_rd_ok,
  input  logic              clr_rx,
  input  logic              clr_ovf,
  input  logic              clr_udf,
  input  logic              clr_crc,
  input  logic              en_rx,
  input  logic              en_ovf,
  input  logic              en_udf,
  input  logic              en_crc,
  output logic              rx_flag,
  output logic              ovf_flag,
  output logic              udf_flag,
  output logic              crc_flag,
  output logic [CNT_W-1:0]  byte_cnt,
  output logic              ep_irq
);
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic          start_ok, done_evt, ovf_evt, udf_evt, crc_evt;
  logic [CNT_W-1:0] rd_ptr;
  logic [AW-1:0] rd_addr;
  logic          rd_acc;
  ep_flags_t     set_v, clr_v, en_v, flags;

  usb_out_bank_rx #(.DEPTH(BANK_BYTES), .AW(AW), .CW(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_byte_vld(pkt_byte_vld),
    .pkt_end(pkt_end), .pkt_crc_bad(pkt_crc_bad), .cfg_iso(cfg_iso),
    .rx_flag(rx_flag), .clr_rx(clr_rx), .wr_en(wr_en), .wr_addr(wr_addr),
    .cnt(byte_cnt), .start_ok(start_ok), .done_evt(done_evt), .ovf_evt(ovf_evt),
    .udf_evt(udf_evt), .crc_evt(crc_evt)
  );

  usb_out_bank_mem #(.DEPTH(BANK_BYTES), .W(DATA_W), .AW(AW)) u_mem (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(pkt_byte),
    .raddr(rd_addr), .rdata(cpu_rd_data)
  );

  // CPU read side
  assign cpu_rd_ok = rx_flag & (rd_ptr < byte_cnt);
  assign rd_acc    = cpu_rd & cpu_rd_ok;
  assign rd_addr   = (rd_ptr < CNT_W'(BANK_BYTES)) ? rd_ptr[AW-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)                  rd_ptr <= '0;
    else if (clr_rx || start_ok) rd_ptr <= '0;
    else if (rd_acc)             rd_ptr <= rd_ptr + 1'b1;
  end

  assign set_v = '{crc: crc_evt, udf: udf_evt, ovf: ovf_evt, rx: done_evt};
  assign clr_v = '{crc: clr_crc, udf: clr_udf, ovf: clr_ovf, rx: clr_rx};
  assign en_v  = '{crc: en_crc,  udf: en_udf,  ovf: en_ovf,  rx: en_rx};

  usb_out_bank_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_v(set_v), .clr_v(clr_v), .en_v(en_v),
    .flags(flags), .irq(ep_irq)
  );

  assign rx_flag  = flags.rx;
  assign ovf_flag = flags.ovf;
  assign udf_flag = flags.udf;
  assign crc_flag = flags.crc;
endmodule

// File: rtl/usb_out_bank_chk.sv
module usb_out_bank_chk
  import usb_out_bank_pkg::*;
#(
  parameter int BANK_BYTES = 64,
  parameter int CNT_W      = $clog2(BANK_BYTES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pkt_end,
  input logic             cfg_iso,
  input logic             cpu_rd,
  input logic             cpu_rd_ok,
  input logic             clr_rx,
  input logic             clr_crc,
  input logic             en_rx, en_ovf, en_udf, en_crc,
  input logic             rx_flag, ovf_flag, udf_flag, crc_flag,
  input logic [CNT_W-1:0] byte_cnt,
  input logic [CNT_W-1:0] rd_ptr,
  input logic             ep_irq,
  input logic             udf_evt,
  input logic             crc_evt,
  input logic             done_evt
);
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_cnt <= CNT_W'(BANK_BYTES));

  assert_drop_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    udf_evt |=> udf_flag);

  assert_drop_keeps_cnt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (udf_evt && !clr_rx) |=> $stable(byte_cnt));

  assert_no_crc_bulk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end && !cfg_iso && !crc_flag) |=> !crc_flag);

  assert_rd_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !cpu_rd_ok && !clr_rx) |=> $stable(rd_ptr));

  assert_clr_rx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rx && !done_evt) |=> (!rx_flag && rd_ptr == '0));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    crc_evt |=> crc_flag);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_flag && !clr_crc) |=> crc_flag);

  assert_irq_lag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flag |=> ep_irq == ($past(en_rx) | ($past(en_ovf) & $past(ovf_flag)) |
                           ($past(en_udf) & $past(udf_flag)) |
                           ($past(en_crc) & $past(crc_flag))));
endmodule

bind usb_out_bank usb_out_bank_chk #(.BANK_BYTES(BANK_BYTES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_end(pkt_end), .cfg_iso(cfg_iso), .cpu_rd(cpu_rd),
  .cpu_rd_ok(cpu_rd_ok), .clr_rx(clr_rx), .clr_crc(clr_crc),
  .en_rx(en_rx), .en_ovf(en_ovf), .en_udf(en_udf), .en_crc(en_crc),
  .rx_flag(rx_flag), .ovf_flag(ovf_flag), .udf_flag(udf_flag), .crc_flag(crc_flag),
  .byte_cnt(byte_cnt), .rd_ptr(rd_ptr), .ep_irq(ep_irq),
  .udf_evt(udf_evt), .crc_evt(crc_evt), .done_evt(done_evt)
);

// File: tb/usb_out_bank_tb.sv
module usb_out_bank_tb;
  localparam int BANK = 16;
  localparam int CW   = $clog2(BANK + 1);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic pkt_start = 0, pkt_byte_vld = 0, pkt_end = 0, pkt_crc_bad = 0, cfg_iso = 0;
  logic [7:0] pkt_byte = '0;
  logic cpu_rd = 0, clr_rx = 0, clr_ovf = 0, clr_udf = 0, clr_crc = 0;
  logic en_rx = 0, en_ovf = 0, en_udf = 0, en_crc = 0;
  logic [7:0] cpu_rd_data;
  logic cpu_rd_ok, rx_flag, ovf_flag, udf_flag, crc_flag, ep_irq;
  logic [CW-1:0] byte_cnt;

  usb_out_bank #(.BANK_BYTES(BANK), .DATA_W(8)) u_dut (.*);

  int nvec = 0, nerr = 0;
  bit finished = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_pkt(int len, logic [7:0] seed, logic iso, logic bad);
    @(negedge clk); cfg_iso = iso; pkt_start = 1;
    @(negedge clk); pkt_start = 0;
    for (int i = 0; i < len; i++) begin
      pkt_byte_vld = 1; pkt_byte = seed + 8'(i);
      @(negedge clk);
    end
    pkt_byte_vld = 0; pkt_end = 1; pkt_crc_bad = bad;
    @(negedge clk); pkt_end = 0; pkt_crc_bad = 0;
  endtask

  task automatic clr(logic r, logic o, logic u, logic c);
    clr_rx = r; clr_ovf = o; clr_udf = u; clr_crc = c;
    @(negedge clk);
    clr_rx = 0; clr_ovf = 0; clr_udf = 0; clr_crc = 0;
  endtask

  task automatic read_chk(string req, int n, logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      chk(req, "read byte", cpu_rd_data, seed + 8'(i));
      cpu_rd = 1; @(negedge clk); cpu_rd = 0;
    end
  endtask

  // {length, iso, crc_bad, seed}
  localparam logic [17:0] VEC [6] = '{
    {8'd4,  1'b0, 1'b0, 8'h10},
    {8'd16, 1'b0, 1'b0, 8'h20},
    {8'd20, 1'b0, 1'b0, 8'h30},
    {8'd5,  1'b1, 1'b1, 8'h40},
    {8'd5,  1'b0, 1'b1, 8'h50},
    {8'd1,  1'b1, 1'b0, 8'h60}
  };

  function automatic logic exp_irq(logic [3:0] f, logic [3:0] e);
    for (int i = 0; i < 4; i++) if (f[i] && e[i]) return 1'b1;
    return 1'b0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nerr++; nvec++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    logic [7:0] d0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "rx_flag", rx_flag, 0);
    chk("R1", "ovf_flag", ovf_flag, 0);
    chk("R1", "udf_flag", udf_flag, 0);
    chk("R1", "crc_flag", crc_flag, 0);
    chk("R1", "byte_cnt", byte_cnt, 0);
    chk("R1", "ep_irq", ep_irq, 0);
    chk("R1", "cpu_rd_ok", cpu_rd_ok, 0);

    // R6 reads into an empty bank are ignored
    d0 = cpu_rd_data;
    repeat (3) begin cpu_rd = 1; @(negedge clk); cpu_rd = 0; end
    chk("R6", "empty data stable", cpu_rd_data, d0);
    send_pkt(3, 8'h70, 0, 0);
    read_chk("R6", 1, 8'h70);
    clr(1, 0, 0, 0);

    // table walk: R2 R3 R5 R6 R7
    foreach (VEC[k]) begin
      int len; int exp_cnt; logic iso, bad; logic [7:0] seed;
      len = int'(VEC[k][17:10]); iso = VEC[k][9]; bad = VEC[k][8]; seed = VEC[k][7:0];
      exp_cnt = (len > BANK) ? BANK : len;
      send_pkt(len, seed, iso, bad);
      chk("R2", "rx_flag", rx_flag, 1);
      chk("R3", "byte_cnt", byte_cnt, exp_cnt);
      chk("R3", "ovf_flag", ovf_flag, len > BANK);
      chk("R5", "crc_flag", crc_flag, iso & bad);
      chk("R4", "udf_flag", udf_flag, 0);
      chk("R6", "rd_ok full", cpu_rd_ok, 1);
      read_chk("R2", exp_cnt, seed);
      chk("R6", "rd_ok drained", cpu_rd_ok, 0);
      d0 = cpu_rd_data;
      cpu_rd = 1; @(negedge clk); cpu_rd = 0;
      chk("R6", "extra read ignored", cpu_rd_data, d0);
      chk("R8", "ovf sticky", ovf_flag, len > BANK);
      clr(1, 1, 1, 1);
      chk("R7", "rx cleared", rx_flag, 0);
      chk("R7", "cnt cleared", byte_cnt, 0);
      chk("R8", "ovf cleared", ovf_flag, 0);
      chk("R8", "crc cleared", crc_flag, 0);
    end

    // R4 packet into a full bank is dropped
    send_pkt(3, 8'hA0, 0, 0);
    send_pkt(2, 8'hB0, 0, 0);
    chk("R4", "udf_flag", udf_flag, 1);
    chk("R4", "cnt kept", byte_cnt, 3);
    chk("R4", "rx kept", rx_flag, 1);
    read_chk("R4", 1, 8'hA0);

    // R8 set wins over a same-cycle clear
    @(negedge clk); pkt_start = 1; clr_udf = 1;
    @(negedge clk); pkt_start = 0; clr_udf = 0; pkt_end = 1;
    @(negedge clk); pkt_end = 0;
    chk("R8", "set beats clear", udf_flag, 1);
    clr(0, 0, 1, 0);
    chk("R8", "udf cleared", udf_flag, 0);
    clr(1, 0, 0, 0);

    // R9 registered, enable-gated interrupt
    send_pkt(20, 8'hC0, 0, 0);
    chk("R9", "irq masked", ep_irq, 0);
    @(negedge clk); en_ovf = 1;
    #1 chk("R9", "irq not yet", ep_irq, 0);
    @(negedge clk);
    chk("R9", "irq on ovf", ep_irq, exp_irq({1'b0, 1'b0, ovf_flag, 1'b0}, 4'b0010));
    clr(0, 1, 0, 0);
    chk("R9", "irq lag after clear", ep_irq, 1);
    @(negedge clk);
    chk("R9", "irq off", ep_irq, 0);
    en_rx = 1;
    @(negedge clk);
    chk("R9", "irq on rx", ep_irq, exp_irq({1'b0, 1'b0, 1'b0, rx_flag}, 4'b0001));
    en_rx = 0; en_ovf = 0;
    clr(1, 0, 0, 0);
    @(negedge clk);
    chk("R9", "irq idle", ep_irq, 0);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule